// File: doc/BRIEF.md
# Two-Level Instruction Control Decoder

This block is the combinational control unit of a single-cycle processor that runs a small 32-bit integer subset: register add and subtract, add-immediate, word load, word store and branch-if-equal. In the same cycle that an instruction word is presented, it produces every datapath control: the register-file write enable, the immediate format, the ALU operand-B source, the memory write enable, the write-back source, the next-PC select and the ALU function.

Decoding happens in two levels. An opcode decoder assigns each opcode one instruction class. From that class it drives the structural controls, a branch-intent flag and a 2-bit ALU mode. An ALU function decoder then turns the mode, funct3, opcode bit 5 and instruction bit 30 into a 3-bit ALU function. The branch select is the branch-intent flag ANDed with the ALU zero flag. Only the branch resolution therefore depends on the datapath. An opcode outside the supported set raises an illegal flag and suppresses every state-changing control.

Top module: `ctl_decode_top`

## Requirements
- R1: The opcode is taken from instruction bits [6:0], funct3 from bits [14:12] and the key bit from bit 30. All other bits have no effect on any output.
- R2: Opcode 0110011 (register class) gives rf_we=1, opb_imm=0, mem_we=0, wb_mem=0, imm_sel=00, no branch, illegal=0.
- R3: Opcode 0010011 (add-immediate) gives rf_we=1, imm_sel=00, opb_imm=1, mem_we=0, wb_mem=0, no branch, illegal=0.
- R4: Opcode 0000011 (load) gives rf_we=1, imm_sel=00, opb_imm=1, wb_mem=1, mem_we=0, no branch, illegal=0.
- R5: Opcode 0100011 (store) gives mem_we=1, imm_sel=01, opb_imm=1, rf_we=0, wb_mem=0, no branch, illegal=0.
- R6: Opcode 1100011 (branch-if-equal) gives imm_sel=10, opb_imm=0, rf_we=0, mem_we=0, wb_mem=0 and pc_br equal to alu_zero.
- R7: ALU function codes are 000 add and 001 subtract. Load and store always select add, and branch always selects subtract, whatever bit 30 and funct3 hold.
- R8: For the register and add-immediate classes, subtract is selected only when funct3 is 000, opcode bit 5 is 1 and bit 30 is 1. Every other case selects add, so add-immediate with bit 30 set stays an add.
- R9: Any other opcode gives illegal=1 with rf_we, mem_we and pc_br at 0, and every other output at 0, whatever alu_zero is.
- R10: alu_zero affects only pc_br. No other output changes when alu_zero toggles.
- R11: imm_sel encodes 00 for I-format, 01 for S-format and 10 for B-format immediates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word being executed |
| alu_zero | input | 1 | ALU result-is-zero flag from the datapath |
| rf_we | output | 1 | Register file write enable |
| imm_sel | output | 2 | Immediate format select (00 I, 01 S, 10 B) |
| opb_imm | output | 1 | ALU operand B: 0 register, 1 immediate |
| mem_we | output | 1 | Data memory write enable |
| wb_mem | output | 1 | Write-back source: 0 ALU result, 1 memory data |
| pc_br | output | 1 | Next PC: 0 sequential, 1 branch target |
| alu_fn | output | 3 | ALU function (000 add, 001 subtract) |
| illegal | output | 1 | Opcode is outside the supported set |

## Verification
Two things can fall in one cycle: the subtract chosen for a branch and the branch-taken decision. The first comes from the opcode, the second from the datapath's zero flag. The bench holds each instruction word constant and applies alu_zero at 0 and then at 1. It expects pc_br to follow alu_zero only for the branch opcode, with alu_fn staying at subtract. For every other word, including illegal opcodes, it expects all outputs to be identical across the two zero values. Words with bit 30 set on the add-immediate, load and branch opcodes show that the key bit influences only the register class.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    localparam int INSTR_W   = 32;
    localparam int OPC_W     = 7;
    localparam int F3_W      = 3;
    localparam int FN_W      = 3;
    localparam int F3_LSB    = 12;
    localparam int KEY_BIT   = 30;
    localparam int OPC_B5    = 5;

    typedef enum logic [OPC_W-1:0] {
        OPC_REG   = 7'b0110011,
        OPC_ADDI  = 7'b0010011,
        OPC_LOAD  = 7'b0000011,
        OPC_STORE = 7'b0100011,
        OPC_BEQ   = 7'b1100011
    } opc_e;

    typedef enum logic [1:0] {
        MODE_ADD   = 2'b00,
        MODE_SUB   = 2'b01,
        MODE_FIELD = 2'b10
    } alu_mode_e;

    typedef enum logic [1:0] {
        IMM_I = 2'b00,
        IMM_S = 2'b01,
        IMM_B = 2'b10
    } imm_e;

    typedef enum logic [FN_W-1:0] {
        FN_ADD = 3'b000,
        FN_SUB = 3'b001
    } alu_fn_e;

    typedef enum logic [2:0] {
        CLS_REG, CLS_ADDI, CLS_LOAD, CLS_STORE, CLS_BEQ, CLS_BAD
    } cls_e;

    typedef struct packed {
        logic      rf_we;
        imm_e      imm_sel;
        logic      opb_imm;
        logic      mem_we;
        logic      wb_mem;
        logic      br_intent;
        alu_mode_e mode;
        logic      illegal;
    } main_ctl_t;

endpackage

// File: rtl/ctl_main_dec.sv
module ctl_main_dec
    import ctl_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output main_ctl_t        ctl
);

    cls_e cls;

    always_comb begin
        unique case (opcode)
            OPC_REG:   cls = CLS_REG;
            OPC_ADDI:  cls = CLS_ADDI;
            OPC_LOAD:  cls = CLS_LOAD;
            OPC_STORE: cls = CLS_STORE;
            OPC_BEQ:   cls = CLS_BEQ;
            default:   cls = CLS_BAD;
        endcase
    end

    always_comb begin
        ctl = '{rf_we: 1'b0, imm_sel: IMM_I, opb_imm: 1'b0, mem_we: 1'b0,
                wb_mem: 1'b0, br_intent: 1'b0, mode: MODE_ADD, illegal: 1'b0};
        unique case (cls)
            CLS_REG: begin
                ctl.rf_we = 1'b1;
                ctl.mode  = MODE_FIELD;
            end
            CLS_ADDI: begin
                ctl.rf_we   = 1'b1;
                ctl.opb_imm = 1'b1;
                ctl.mode    = MODE_FIELD;
            end
            CLS_LOAD: begin
                ctl.rf_we   = 1'b1;
                ctl.opb_imm = 1'b1;
                ctl.wb_mem  = 1'b1;
            end
            CLS_STORE: begin
                ctl.mem_we  = 1'b1;
                ctl.opb_imm = 1'b1;
                ctl.imm_sel = IMM_S;
            end
            CLS_BEQ: begin
                ctl.br_intent = 1'b1;
                ctl.imm_sel   = IMM_B;
                ctl.mode      = MODE_SUB;
            end
            default: ctl.illegal = 1'b1;
        endcase
    end

    // memory read-back always lands in the register file
    always_comb begin
        assert_load_writes_rf_R4: assert (!ctl.wb_mem || (ctl.rf_we && ctl.opb_imm));
        assert_store_no_rf_R5:    assert (!ctl.mem_we || (!ctl.rf_we && ctl.imm_sel == IMM_S));
    end

endmodule

// File: rtl/ctl_alu_dec.sv
module ctl_alu_dec
    import ctl_pkg::*;
(
    input  alu_mode_e       mode,
    input  logic [F3_W-1:0] funct3,
    input  logic            opc_b5,
    input  logic            key_bit,
    output alu_fn_e         fn
);

    logic want_sub;
    assign want_sub = (funct3 == 3'b000) && opc_b5 && key_bit;

    always_comb begin
        unique case (mode)
            MODE_ADD:   fn = FN_ADD;
            MODE_SUB:   fn = FN_SUB;
            MODE_FIELD: fn = want_sub ? FN_SUB : FN_ADD;
            default:    fn = FN_ADD;
        endcase
    end

    // forced modes ignore the instruction fields
    always_comb begin
        assert_forced_add_R7: assert (mode != MODE_ADD || fn == FN_ADD);
        assert_imm_keeps_add_R8: assert (opc_b5 || fn != FN_SUB || mode == MODE_SUB);
    end

endmodule

// File: rtl/ctl_decode_top.sv
module ctl_decode_top
    import ctl_pkg::*;
(
    input  logic [31:0] instr,
    input  logic        alu_zero,
    output logic        rf_we,
    output logic [1:0]  imm_sel,
    output logic        opb_imm,
    output logic        mem_we,
    output logic        wb_mem,
    output logic        pc_br,
    output logic [2:0]  alu_fn,
    output logic        illegal
);

    logic [OPC_W-1:0] opcode;
    logic [F3_W-1:0]  funct3;
    logic             key_bit;
    main_ctl_t        mctl;
    alu_fn_e          fn;
    logic             unused_bits;

    assign opcode      = instr[OPC_W-1:0];
    assign funct3      = instr[F3_LSB +: F3_W];
    assign key_bit     = instr[KEY_BIT];
    assign unused_bits = ^{instr[INSTR_W-1], instr[KEY_BIT-1:F3_LSB+F3_W], instr[F3_LSB-1:OPC_W]};

    ctl_main_dec u_main (
        .opcode (opcode),
        .ctl    (mctl)
    );

    ctl_alu_dec u_alu (
        .mode    (mctl.mode),
        .funct3  (funct3),
        .opc_b5  (opcode[OPC_B5]),
        .key_bit (key_bit),
        .fn      (fn)
    );

    assign rf_we   = mctl.rf_we;
    assign imm_sel = mctl.imm_sel;
    assign opb_imm = mctl.opb_imm;
    assign mem_we  = mctl.mem_we;
    assign wb_mem  = mctl.wb_mem;
    assign pc_br   = mctl.br_intent & alu_zero;
    assign alu_fn  = fn;
    assign illegal = mctl.illegal;

    always_comb begin
        assert_illegal_quiet_R9:   assert (!illegal || !(rf_we || mem_we || pc_br));
        assert_branch_on_zero_R6:  assert (!pc_br || (alu_zero && alu_fn == FN_SUB));
        assert_branch_no_write_R6: assert (!pc_br || (!rf_we && !mem_we));
    end

endmodule

// File: tb/tb_ctl_decode_top.sv
module tb_ctl_decode_top;

    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 13;
    localparam int WATCHDOG   = 5000;

    // {instr, expected {rf_we, imm_sel[1:0], opb_imm, mem_we, wb_mem, alu_fn[2:0], illegal}, branch}
    localparam logic [42:0] VEC [N_VEC] = '{
        {32'h002081B3, 10'b1_00_0_0_0_000_0, 1'b0},
        {32'h402081B3, 10'b1_00_0_0_0_001_0, 1'b0},
        {32'h00408193, 10'b1_00_1_0_0_000_0, 1'b0},
        {32'h40008193, 10'b1_00_1_0_0_000_0, 1'b0},
        {32'h0000A183, 10'b1_00_1_0_1_000_0, 1'b0},
        {32'h4000A183, 10'b1_00_1_0_1_000_0, 1'b0},
        {32'h0030A023, 10'b0_01_1_1_0_000_0, 1'b0},
        {32'h00208463, 10'b0_10_0_0_0_001_0, 1'b1},
        {32'h00000000, 10'b0_00_0_0_0_000_1, 1'b0},
        {32'h0000006F, 10'b0_00_0_0_0_000_1, 1'b0},
        {32'hFFFFFFFF, 10'b0_00_0_0_0_000_1, 1'b0},
        {32'h4020C1B3, 10'b1_00_0_0_0_000_0, 1'b0},
        {32'h40208463, 10'b0_10_0_0_0_001_0, 1'b1}
    };

    logic        clk = 1'b0;
    logic [31:0] instr = 32'h0;
    logic        alu_zero = 1'b0;
    logic        rf_we, opb_imm, mem_we, wb_mem, pc_br, illegal;
    logic [1:0]  imm_sel;
    logic [2:0]  alu_fn;
    int          checks = 0;
    int          errors = 0;
    int          cycles = 0;

    ctl_decode_top dut (
        .instr    (instr),
        .alu_zero (alu_zero),
        .rf_we    (rf_we),
        .imm_sel  (imm_sel),
        .opb_imm  (opb_imm),
        .mem_we   (mem_we),
        .wb_mem   (wb_mem),
        .pc_br    (pc_br),
        .alu_fn   (alu_fn),
        .illegal  (illegal)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic string tag_of(int idx);
        case (idx)
            0:       return "R2";
            1, 3:    return "R8";
            2:       return "R3";
            4:       return "R4";
            5, 12:   return "R7";
            6:       return "R5";
            7:       return "R6";
            8, 9, 10: return "R9";
            default: return "R8";
        endcase
    endfunction

    function automatic logic [9:0] observed();
        return {rf_we, imm_sel, opb_imm, mem_we, wb_mem, alu_fn, illegal};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s instr=%h zero=%0b actual=%h expected=%h", req, instr, alu_zero, act, exp);
        end
    endtask

    task automatic apply(logic [31:0] w, logic z);
        @(negedge clk);
        instr    = w;
        alu_zero = z;
        @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        while (cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog R1 actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [9:0] first;
        // idle state: all-zero word is quiet and flagged (R9)
        apply(32'h0, 1'b0);
        check("R9", {22'h0, observed()}, {22'h0, 10'b0_00_0_0_0_000_1});
        check("R9", {31'h0, pc_br}, 32'h0);

        for (int i = 0; i < N_VEC; i++) begin
            for (int z = 0; z < 2; z++) begin
                apply(VEC[i][42:11], z[0]);
                check(tag_of(i), {22'h0, observed()}, {22'h0, VEC[i][10:1]});
                check("R6", {31'h0, pc_br}, {31'h0, VEC[i][0] & z[0]});
            end
        end

        // R10: zero toggle leaves every non-branch output unchanged
        for (int i = 0; i < N_VEC; i++) begin
            apply(VEC[i][42:11], 1'b0);
            first = observed();
            apply(VEC[i][42:11], 1'b1);
            check("R10", {22'h0, observed()}, {22'h0, first});
        end

        // R1: bits outside the fields are ignored (load with noise everywhere else)
        apply(32'hBFFF0F83 & 32'hBFFF8FFF | 32'h00002000, 1'b1);
        check("R1", {22'h0, observed()}, {22'h0, 10'b1_00_1_0_1_000_0});
        // R1: opcode bits only in [6:0]; store opcode shifted up is illegal
        apply(32'h00000000 | (32'h23 << 7), 1'b1);
        check("R1", {31'h0, illegal}, 32'h1);

        // R11: immediate format codes per class
        apply(32'h0030A023, 1'b0);
        check("R11", {30'h0, imm_sel}, 32'h1);
        apply(32'h00208463, 1'b0);
        check("R11", {30'h0, imm_sel}, 32'h2);
        apply(32'h00408193, 1'b0);
        check("R11", {30'h0, imm_sel}, 32'h0);

        // R8: register class with funct3=000 but bit30 clear stays add
        apply(32'h002081B3, 1'b1);
        check("R8", {29'h0, alu_fn}, 32'h0);
        // R9: illegal opcode with zero high never branches
        apply(32'h00208467, 1'b1);
        check("R9", {30'h0, pc_br, illegal}, 32'h1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule